// File: doc/BRIEF.md
# TLB replacement counter and control register

This block is the software-visible control word of a memory-management unit, with a 6-bit replacement index counter built into it. The counter names the unified translation-buffer entry that the next load-TLB instruction will overwrite. It advances once for each buffer access. When software has set a nonzero boundary, the counter wraps back to 0 at that boundary. The same word holds a translation-enable bit, a bit that selects between one shared virtual space and several virtual spaces, and a bit that limits store-queue access to privileged code. It also has a write-only strobe that invalidates every entry in both translation buffers.

Software reaches the word through a single-register bus: a write strobe with write data, and read data that always shows the current state. Two sideband inputs come from the translation pipeline: one pulses for each buffer access and one pulses for each load-TLB instruction. The block turns the enable and privilege bits into two outputs. One flags an address error for a store-queue access made in user mode. The other passes a raw translation fault on as an exception only while translation is enabled.

Top module: `mmu_ctl_reg`

## Requirements
- R1: While reset is asserted and after it is released, the replacement index is 0 and the read data, the invalidate pulse, the mode outputs and both exception outputs are 0.
- R2: With a boundary of 0, each buffer access (no write, no load-TLB) raises the index by one in the following cycle, and 63 is followed by 0.
- R3: With a nonzero boundary, an access made while the index equals the boundary sets the index to 0.
- R4: If the index is above a nonzero boundary, accesses carry it upward through 63, then to 0, and from there the boundary wrap of R3 applies again.
- R5: A cycle with the load-TLB input high leaves the index unchanged, even when an access is signalled in the same cycle.
- R6: A register write loads the index from write bits [15:10] in the next cycle and takes priority over a same-cycle access.
- R7: A write with bit 1 set gives a single-cycle pulse on the invalidate output in the cycle after the write. A write with bit 1 clear gives no pulse. Bit 1 always reads as 0.
- R8: The store-queue address error is high only when a store-queue access is made in user mode while the privileged-only bit (bit 3) is 1.
- R9: The translation fault output follows the raw fault input only while the enable bit (bit 0) is 1, and it is 0 whenever that bit is 0.
- R10: The word reads back as index [15:10], boundary [9:4], privileged-only [3], single-space [2], 0 at [1] and enable [0], and the three mode bits appear on their own outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Current register contents |
| utlb_acc | input | 1 | One unified translation-buffer access this cycle |
| ldtlb_exec | input | 1 | A load-TLB instruction executes this cycle |
| sq_acc | input | 1 | Store-queue access this cycle |
| user_mode | input | 1 | Current access is made in user mode |
| xlat_fault_raw | input | 1 | Raw translation fault from the compare logic |
| repl_idx | output | 6 | Replacement index |
| inval_all | output | 1 | One-cycle invalidate-all pulse |
| single_space | output | 1 | 1 selects single virtual space, 0 selects multiple |
| sq_priv_only | output | 1 | Store queues limited to privileged access |
| xlat_en | output | 1 | Address translation enabled |
| sq_addr_err | output | 1 | Address error for a user store-queue access |
| xlat_fault | output | 1 | Translation fault, gated by the enable bit |

## Verification
The counter is driven by runs of accesses under three boundary settings. A zero boundary shows free counting and the 63-to-0 rollover. A small boundary starting below it shows the early wrap. A start value above the boundary separates the run through 63 from an early wrap at the boundary. Load-TLB cycles, with and without a coincident access, separate holding from stepping, and a write that coincides with an access shows which one wins. All four combinations of privilege and store-queue access are tried under both privileged-only settings, and raw faults are applied with translation both on and off, so the gating terms can be told apart.

// File: rtl/mmu_ctl_pkg.sv
// Package: field widths and bit positions of the MMU control word.
// Assumes the counter and boundary fields have the same width.
package mmu_ctl_pkg;
    parameter int IDX_W   = 6;
    localparam int REG_W   = 4 + 2 * IDX_W;
    localparam int POS_XEN = 0;
    localparam int POS_INV = 1;
    localparam int POS_SS  = 2;
    localparam int POS_SQP = 3;
    localparam int POS_BND = 4;
    localparam int POS_CNT = 4 + IDX_W;

    typedef struct packed {
        logic sq_priv;
        logic sspace;
        logic xen;
    } mode_bits_t;
endpackage

// File: rtl/mmu_repl_counter.sv
// Module: replacement index counter.
// Load takes priority over stepping, and a hold input blocks stepping.
// The counter wraps to 0 at a nonzero bound. A value above the bound
// runs on to all ones and then rolls over naturally.
module mmu_repl_counter #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    input  logic         hold,
    input  logic [W-1:0] bound,
    output logic [W-1:0] cnt
);
    logic         at_bound;
    logic [W-1:0] cnt_next;

    // Detect an active boundary match.
    always_comb begin
        at_bound = (bound != '0) && (cnt == bound);
    end

    // Choose the next counter value.
    always_comb begin
        cnt_next = cnt;
        if (load) begin
            cnt_next = load_val;
        end else if (step && !hold) begin
            cnt_next = at_bound ? '0 : cnt + 1'b1;
        end
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            cnt <= cnt_next;
        end
    end
endmodule

// File: rtl/mmu_ctl_fields.sv
// Module: write decode, field storage, invalidate pulse and readback.
// Assumes a whole-word write strobe. The invalidate bit is not stored
// and always reads as 0.
module mmu_ctl_fields
    import mmu_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic [IDX_W-1:0] cnt,
    output logic [IDX_W-1:0] bound,
    output mode_bits_t       modes,
    output logic             inval,
    output logic [REG_W-1:0] rdata
);
    // Store the boundary and mode fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bound <= '0;
            modes <= '0;
        end else if (wr) begin
            bound         <= wdata[POS_BND +: IDX_W];
            modes.xen     <= wdata[POS_XEN];
            modes.sspace  <= wdata[POS_SS];
            modes.sq_priv <= wdata[POS_SQP];
        end
    end

    // Pulse invalidate for one cycle after a write that sets the bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inval <= 1'b0;
        end else begin
            inval <= wr && wdata[POS_INV];
        end
    end

    // Assemble the read view.
    always_comb begin
        rdata                      = '0;
        rdata[POS_XEN]             = modes.xen;
        rdata[POS_SS]              = modes.sspace;
        rdata[POS_SQP]             = modes.sq_priv;
        rdata[POS_BND +: IDX_W]    = bound;
        rdata[POS_CNT +: IDX_W]    = cnt;
    end
endmodule

// File: rtl/mmu_exc_gate.sv
// Module: exception qualification from the mode bits.
// Purely combinational. The raw fault comes from outside the block.
module mmu_exc_gate
    import mmu_ctl_pkg::*;
(
    input  mode_bits_t modes,
    input  logic       sq_acc,
    input  logic       user_mode,
    input  logic       fault_raw,
    output logic       sq_err,
    output logic       fault
);
    // Qualify the store-queue error and the translation fault.
    always_comb begin
        sq_err = sq_acc && user_mode && modes.sq_priv;
        fault  = fault_raw && modes.xen;
    end
endmodule

// File: rtl/mmu_ctl_reg.sv
// Module: top of the MMU control register with its replacement counter.
// Assumes at most one buffer access and one load-TLB per cycle.
module mmu_ctl_reg
    import mmu_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             utlb_acc,
    input  logic             ldtlb_exec,
    input  logic             sq_acc,
    input  logic             user_mode,
    input  logic             xlat_fault_raw,
    output logic [IDX_W-1:0] repl_idx,
    output logic             inval_all,
    output logic             single_space,
    output logic             sq_priv_only,
    output logic             xlat_en,
    output logic             sq_addr_err,
    output logic             xlat_fault
);
    logic [IDX_W-1:0] bound_q;
    mode_bits_t       modes_q;

    mmu_repl_counter #(.W(IDX_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (reg_wr),
        .load_val (reg_wdata[POS_CNT +: IDX_W]),
        .step     (utlb_acc),
        .hold     (ldtlb_exec),
        .bound    (bound_q),
        .cnt      (repl_idx)
    );

    mmu_ctl_fields u_fields (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .wdata (reg_wdata),
        .cnt   (repl_idx),
        .bound (bound_q),
        .modes (modes_q),
        .inval (inval_all),
        .rdata (reg_rdata)
    );

    mmu_exc_gate u_exc (
        .modes     (modes_q),
        .sq_acc    (sq_acc),
        .user_mode (user_mode),
        .fault_raw (xlat_fault_raw),
        .sq_err    (sq_addr_err),
        .fault     (xlat_fault)
    );

    // Drive the mode outputs from the stored fields.
    always_comb begin
        single_space = modes_q.sspace;
        sq_priv_only = modes_q.sq_priv;
        xlat_en      = modes_q.xen;
    end
endmodule

// File: rtl/mmu_ctl_reg_chk.sv
// Module: assertion checker bound to mmu_ctl_reg.
// Observes ports and the stored boundary only, and drives nothing.
module mmu_ctl_reg_chk
    import mmu_ctl_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic             utlb_acc,
    input logic             ldtlb_exec,
    input logic [IDX_W-1:0] repl_idx,
    input logic [IDX_W-1:0] bound_q,
    input logic             inval_all,
    input logic             sq_acc,
    input logic             user_mode,
    input logic             sq_priv_only,
    input logic             sq_addr_err,
    input logic             xlat_en,
    input logic             xlat_fault
);
    localparam logic [IDX_W-1:0] TOP = '1;

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && utlb_acc && !ldtlb_exec && !(bound_q != '0 && repl_idx == bound_q))
        |=> repl_idx == $past(repl_idx) + 1'b1); // R2
    AST_BOUND_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && utlb_acc && !ldtlb_exec && bound_q != '0 && repl_idx == bound_q)
        |=> repl_idx == '0); // R3
    AST_TOP_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && utlb_acc && !ldtlb_exec && repl_idx == TOP)
        |=> repl_idx == '0); // R4
    AST_LDTLB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && ldtlb_exec) |=> $stable(repl_idx)); // R5
    AST_WR_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> repl_idx == $past(reg_wdata[POS_CNT +: IDX_W])); // R6
    AST_INV_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        inval_all |-> $past(reg_wr && reg_wdata[POS_INV])); // R7
    AST_INV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[POS_INV]); // R7
    AST_SQ_ERR_COND: assert property (@(posedge clk) disable iff (!rst_n)
        sq_addr_err |-> (sq_acc && user_mode && sq_priv_only)); // R8
    AST_FAULT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !xlat_en |-> !xlat_fault); // R9
endmodule

bind mmu_ctl_reg mmu_ctl_reg_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .utlb_acc     (utlb_acc),
    .ldtlb_exec   (ldtlb_exec),
    .repl_idx     (repl_idx),
    .bound_q      (bound_q),
    .inval_all    (inval_all),
    .sq_acc       (sq_acc),
    .user_mode    (user_mode),
    .sq_priv_only (sq_priv_only),
    .sq_addr_err  (sq_addr_err),
    .xlat_en      (xlat_en),
    .xlat_fault   (xlat_fault)
);

// File: tb/mmu_ctl_reg_tb.sv
// Scoreboard bench: the driver pushes expected items, the monitor compares them.
module mmu_ctl_reg_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        utlb_acc = 1'b0, ldtlb_exec = 1'b0, sq_acc = 1'b0;
    logic        user_mode = 1'b0, xlat_fault_raw = 1'b0;
    logic [5:0]  repl_idx;
    logic        inval_all, single_space, sq_priv_only, xlat_en;
    logic        sq_addr_err, xlat_fault;

    int total = 0;
    int bad = 0;

    typedef struct {
        string       tag;
        int          sel;
        logic [15:0] exp;
    } item_t;
    item_t sb[$];

    // Reference state built from the requirements.
    logic [5:0] m_idx = '0, m_bnd = '0;
    logic       m_ss = 1'b0, m_sqp = 1'b0, m_xen = 1'b0;

    always #2 clk = ~clk;

    mmu_ctl_reg u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .utlb_acc(utlb_acc), .ldtlb_exec(ldtlb_exec),
        .sq_acc(sq_acc), .user_mode(user_mode), .xlat_fault_raw(xlat_fault_raw),
        .repl_idx(repl_idx), .inval_all(inval_all), .single_space(single_space),
        .sq_priv_only(sq_priv_only), .xlat_en(xlat_en),
        .sq_addr_err(sq_addr_err), .xlat_fault(xlat_fault)
    );

    function automatic logic [15:0] mk(logic [5:0] idx, logic [5:0] bnd,
                                       logic sqp, logic ss, logic inv, logic xen);
        return {idx, bnd, sqp, ss, inv, xen};
    endfunction

    task automatic check(string tag, string what, logic [15:0] got, logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    function automatic logic [15:0] observe(int sel);
        case (sel)
            0: return {10'd0, repl_idx};
            1: return reg_rdata;
            2: return {15'd0, inval_all};
            3: return {15'd0, sq_addr_err};
            4: return {15'd0, xlat_fault};
            default: return {13'd0, single_space, sq_priv_only, xlat_en};
        endcase
    endfunction

    // Monitor: compares queued expectations just after each edge.
    always @(posedge clk) begin
        #1;
        while (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(it.tag, $sformatf("sel%0d", it.sel), observe(it.sel), it.exp);
        end
    end

    // Driver: applies one cycle of stimulus and queues the expected results.
    task automatic step(string tag, bit wr, logic [15:0] wd, bit acc, bit ld,
                        bit sq, bit usr, bit flt);
        logic inv_n;
        @(negedge clk);
        reg_wr = wr; reg_wdata = wd; utlb_acc = acc; ldtlb_exec = ld;
        sq_acc = sq; user_mode = usr; xlat_fault_raw = flt;
        inv_n = 1'b0;
        if (wr) begin
            m_idx = wd[15:10]; m_bnd = wd[9:4]; m_sqp = wd[3];
            m_ss = wd[2]; m_xen = wd[0]; inv_n = wd[1];
        end else if (acc && !ld) begin
            m_idx = (m_bnd != 0 && m_idx == m_bnd) ? 6'd0 : m_idx + 6'd1;
        end
        @(posedge clk);
        sb.push_back('{tag, 0, {10'd0, m_idx}});
        sb.push_back('{tag, 1, mk(m_idx, m_bnd, m_sqp, m_ss, 1'b0, m_xen)});
        sb.push_back('{tag, 2, {15'd0, inv_n}});
        sb.push_back('{tag, 3, {15'd0, sq && usr && m_sqp}});
        sb.push_back('{tag, 4, {15'd0, flt && m_xen}});
        sb.push_back('{tag, 5, {13'd0, m_ss, m_sqp, m_xen}});
    endtask

    task automatic acc_n(string tag, int n);
        for (int i = 0; i < n; i++) step(tag, 0, '0, 1, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: state during reset.
        repeat (3) @(posedge clk);
        #1;
        check("R1", "idx", {10'd0, repl_idx}, 16'd0);
        check("R1", "rdata", reg_rdata, 16'd0);
        check("R1", "inval", {15'd0, inval_all}, 16'd0);
        @(negedge clk); rst_n = 1'b1;
        step("R1", 0, '0, 0, 0, 1, 1, 1);
        // R2: free counting with a zero boundary, then rollover.
        acc_n("R2", 5);
        step("R6", 1, mk(6'd62, 6'd0, 0, 0, 0, 0), 0, 0, 0, 0, 0);
        acc_n("R2", 3);
        // R3: wrap at a small boundary.
        step("R10", 1, mk(6'd0, 6'd3, 0, 1, 0, 0), 0, 0, 0, 0, 0);
        acc_n("R3", 6);
        // R4: start above the boundary.
        step("R10", 1, mk(6'd60, 6'd3, 1, 0, 0, 1), 0, 0, 0, 0, 0);
        acc_n("R4", 9);
        // R5: load-TLB holds, alone and with an access.
        step("R5", 0, '0, 0, 1, 0, 0, 0);
        step("R5", 0, '0, 1, 1, 0, 0, 0);
        acc_n("R5", 1);
        // R6: write beats a same-cycle access.
        step("R6", 1, mk(6'd40, 6'd0, 0, 0, 0, 0), 1, 0, 0, 0, 0);
        acc_n("R6", 1);
        // R7: invalidate pulse and its absence.
        step("R7", 1, mk(6'd41, 6'd0, 0, 0, 1, 0), 0, 0, 0, 0, 0);
        step("R7", 0, '0, 0, 0, 0, 0, 0);
        step("R7", 1, mk(6'd41, 6'd0, 0, 0, 0, 0), 0, 0, 0, 0, 0);
        step("R7", 1, mk(6'd41, 6'd0, 0, 0, 1, 0), 0, 0, 0, 0, 0);
        step("R7", 1, mk(6'd41, 6'd0, 0, 0, 1, 0), 0, 0, 0, 0, 0);
        step("R7", 0, '0, 0, 0, 0, 0, 0);
        // R8: store-queue privilege under both settings.
        for (int p = 0; p < 2; p++) begin
            step("R8", 1, mk(6'd0, 6'd0, p[0], 0, 0, 0), 0, 0, 0, 0, 0);
            step("R8", 0, '0, 0, 0, 1, 1, 0);
            step("R8", 0, '0, 0, 0, 1, 0, 0);
            step("R8", 0, '0, 0, 0, 0, 1, 0);
            step("R8", 0, '0, 0, 0, 0, 0, 0);
        end
        // R9: fault gating by the enable bit.
        step("R9", 1, mk(6'd0, 6'd0, 0, 0, 0, 0), 0, 0, 0, 0, 1);
        step("R9", 0, '0, 0, 0, 0, 0, 1);
        step("R9", 1, mk(6'd0, 6'd0, 0, 0, 0, 1), 0, 0, 0, 0, 1);
        step("R9", 0, '0, 0, 0, 0, 0, 1);
        step("R9", 0, '0, 0, 0, 0, 0, 0);
        // R10: full readback pattern.
        step("R10", 1, mk(6'd21, 6'd42, 1, 1, 1, 1), 0, 0, 0, 0, 0);
        step("R10", 0, '0, 0, 0, 0, 0, 0);
        @(negedge clk);
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule